// File: doc/BRIEF.md
# Selectable G.711 Sample Compressor

This block turns 16-bit two's-complement audio samples into 8-bit logarithmic codes, following either the µ-law or the A-law curve of G.711. Each law is built as a piecewise-linear segment encoder. A law select input picks the curve and an enable input switches companding on. When companding is off, a second mode input can ask for plain 8-bit linear words, which are the top byte of the sample. When both inputs are off, the whole sample passes through unchanged.

Each sample arrives with a valid strobe. One clock later the result appears on a 16-bit output word, also with a valid strobe. In the 8-bit modes the byte sits in the most significant eight positions of that word, because a serial port shifts the word out MSB first. A byte-wide copy of the top of the word is also provided, so that a port running back-to-back 8-bit slots can take it directly.

Top module: `g711_compressor`

## Requirements
- R1: `out_valid` is low after reset and follows `in_valid` with exactly one clock of latency. A result registered from an input sample appears on the outputs in that same cycle.
- R2: Mode precedence works as follows. With `comp_en`=1 the output is companded whatever `byte_mode` is. With `comp_en`=0 and `byte_mode`=1 the output is linear truncation. With both at 0 the output is the pass-through.
- R3: µ-law (`law_sel`=0) forms a magnitude from sample bits 15:2, taken as a 14-bit signed value, and adds 33. The exponent (code bits 6:4, before inversion) is the index k in 0..7 of the highest set bit at position k+5. The mantissa (bits 3:0) is the four bits just below that bit.
- R4: In µ-law the magnitude is limited to 8158 before the bias is added. The most negative 14-bit value saturates to 8191 rather than wrapping. Full-scale positive therefore gives 0x80 and full-scale negative gives 0x00.
- R5: A-law (`law_sel`=1) forms a magnitude from sample bits 15:3, taken as a 13-bit signed value, with the most negative value saturated to 4095. For a magnitude of 32 or more, the exponent is the leading-one position minus 4 and the mantissa is the four bits just below the leading one. Full-scale positive gives 0xAA and full-scale negative gives 0x2A.
- R6: In A-law, a magnitude below 32 gives exponent 0 with mantissa equal to magnitude bits 4:1.
- R7: After inversion, bit 7 of the code is 1 for a zero or positive sample and 0 for a negative one. µ-law codes have all eight bits inverted; A-law codes are XORed with 0x55. Zero therefore encodes to 0xFF in µ-law and to 0xD5 in A-law.
- R8: In both 8-bit modes, `out_word` is the byte followed by eight zero bits. `out_byte` always equals `out_word[15:8]`.
- R9: In linear 8-bit mode the byte is sample bits 15:8. In pass-through, `out_word` equals the input sample.
- R10: In a cycle with `in_valid` low, `out_word` and `out_byte` keep their previous values and `out_valid` goes low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Linear two's-complement sample |
| comp_en | input | 1 | 1 = companding on |
| law_sel | input | 1 | 0 = µ-law, 1 = A-law |
| byte_mode | input | 1 | 1 = linear 8-bit words when companding is off |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_word | output | 16 | Result word, MSB-aligned in the 8-bit modes |
| out_byte | output | 8 | Top byte of `out_word` |

## Verification
The hardest cases to reach are at the edges of the magnitude path. One is the µ-law clip band, where magnitudes 8159 to 8191 must all map to the top code. The other is the single most-negative value of each law's signed field, which has to saturate instead of wrapping. Uniform random samples almost never land on these points. For that reason the stimulus drives every segment boundary on both sides, and both signs, as directed values built from shifted powers of two. On top of that, a random phase draws a large share of its samples from the top and bottom few hundred codes of the range. The same random phase also sets `comp_en` and `byte_mode` together, to cover the precedence rule.

// File: rtl/g711_comp_pkg.sv
// Shared sizes and mode encoding for the G.711 compressor.
// Assumes a 16-bit sample. The field widths follow from the two laws.
package g711_comp_pkg;
    localparam int SAMPLE_W = 16;
    localparam int CODE_W   = 8;
    localparam int MU_FLD_W = 14;   // signed field fed to the µ-law path
    localparam int A_FLD_W  = 13;   // signed field fed to the A-law path
    localparam int MU_MAG_W = MU_FLD_W - 1;
    localparam int A_MAG_W  = A_FLD_W - 1;
    localparam int MU_CLIP  = 8158;
    localparam int MU_BIAS  = 33;
    localparam logic [CODE_W-1:0] MU_FLIP = 8'hFF;
    localparam logic [CODE_W-1:0] A_FLIP  = 8'h55;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_LIN8 = 2'd1,
        MODE_COMP = 2'd2
    } out_mode_t;
endpackage

// File: rtl/g711_sign_mag.sv
// Splits the top FLD_W bits of a sample into a sign flag and a magnitude.
// The most negative field value saturates to the largest magnitude.
// Assumes FLD_W <= IN_W. Purely combinational.
module g711_sign_mag #(
    parameter int IN_W  = 16,
    parameter int FLD_W = 14,
    localparam int MAG_W = FLD_W - 1
) (
    input  logic [IN_W-1:0]  sample,
    output logic             neg,
    output logic [MAG_W-1:0] mag
);
    logic [FLD_W-1:0] fld;
    logic [FLD_W-1:0] negated;
    logic             is_min;

    // Take the field, negate it if negative, and saturate the one value that does not fit.
    always_comb begin
        fld     = sample[IN_W-1 -: FLD_W];
        neg     = fld[FLD_W-1];
        negated = ~fld + {{(FLD_W-1){1'b0}}, 1'b1};
        is_min  = neg && (fld[FLD_W-2:0] == '0);
        if (!neg)
            mag = fld[MAG_W-1:0];
        else if (is_min)
            mag = '1;
        else
            mag = negated[MAG_W-1:0];
    end
endmodule

// File: rtl/g711_mu_segment.sv
// µ-law segment encoder: clips the magnitude, adds the bias, finds the
// exponent from the leading one in bits 12:5 and takes four mantissa bits.
// Output is {exponent, mantissa} before any inversion. Combinational.
module g711_mu_segment
    import g711_comp_pkg::*;
(
    input  logic [MU_MAG_W-1:0] mag,
    output logic [2:0]          exponent,
    output logic [3:0]          mantissa
);
    logic [MU_MAG_W-1:0] clipped;
    logic [MU_MAG_W-1:0] biased;
    logic [MU_MAG_W-1:0] shifted;

    // Clip and bias so that the leading one always falls in bits 12:5.
    always_comb begin
        clipped = (mag > MU_MAG_W'(MU_CLIP)) ? MU_MAG_W'(MU_CLIP) : mag;
        biased  = clipped + MU_MAG_W'(MU_BIAS);
    end

    // Priority search for the highest set bit at positions 5..12.
    always_comb begin
        exponent = 3'd0;
        for (int k = 0; k < 8; k++) begin
            if (biased[k+5]) exponent = 3'(k);
        end
        shifted  = biased >> exponent;
        mantissa = shifted[4:1];
    end

    // R3: the bias must always put a one at or above bit 5.
    always_comb begin
        if (!$isunknown(mag))
            assert_mu_bias_floor_R3: assert (biased[MU_MAG_W-1:5] != '0);
    end
endmodule

// File: rtl/g711_a_segment.sv
// A-law segment encoder: magnitudes below 32 form a linear segment 0 and
// larger ones use the leading-one position minus 4 as the exponent.
// Output is {exponent, mantissa} before any inversion. Combinational.
module g711_a_segment
    import g711_comp_pkg::*;
(
    input  logic [A_MAG_W-1:0] mag,
    output logic [2:0]         exponent,
    output logic [3:0]         mantissa
);
    logic [A_MAG_W-1:0] shifted;

    // Priority search over bits 5..11. Bits below that stay in segment 0.
    always_comb begin
        exponent = 3'd0;
        for (int k = 1; k < 8; k++) begin
            if (mag[k+4]) exponent = 3'(k);
        end
        shifted  = mag >> exponent;
        mantissa = (exponent == 3'd0) ? mag[4:1] : shifted[3:0];
    end

    // R5/R6: the exponent is non-zero exactly when the magnitude reaches 32.
    always_comb begin
        if (!$isunknown(mag))
            assert_a_seg_split_R6: assert ((exponent != 3'd0) == (mag >= A_MAG_W'(32)));
    end
endmodule

// File: rtl/g711_compressor.sv
// Top of the G.711 compressor. Selects µ-law, A-law, linear 8-bit or
// pass-through output and registers the result with one cycle of latency.
// Assumes the control inputs are stable around each valid sample.
module g711_compressor
    import g711_comp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                comp_en,
    input  logic                law_sel,
    input  logic                byte_mode,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_word,
    output logic [CODE_W-1:0]   out_byte
);
    logic                mu_neg, a_neg;
    logic [MU_MAG_W-1:0] mu_mag;
    logic [A_MAG_W-1:0]  a_mag;
    logic [2:0]          mu_exp, a_exp;
    logic [3:0]          mu_man, a_man;
    logic [CODE_W-1:0]   code;
    logic [CODE_W-1:0]   byte_val;
    out_mode_t           mode;
    logic [SAMPLE_W-1:0] next_word;

    g711_sign_mag #(.IN_W(SAMPLE_W), .FLD_W(MU_FLD_W)) i_mu_sm (
        .sample(in_sample), .neg(mu_neg), .mag(mu_mag));

    g711_sign_mag #(.IN_W(SAMPLE_W), .FLD_W(A_FLD_W)) i_a_sm (
        .sample(in_sample), .neg(a_neg), .mag(a_mag));

    g711_mu_segment i_mu_seg (.mag(mu_mag), .exponent(mu_exp), .mantissa(mu_man));

    g711_a_segment  i_a_seg  (.mag(a_mag),  .exponent(a_exp),  .mantissa(a_man));

    // Form the code with its sign, then apply the inversion mask of the law.
    always_comb begin
        if (!law_sel)
            code = {mu_neg, mu_exp, mu_man} ^ MU_FLIP;
        else
            code = {~a_neg, a_exp, a_man} ^ A_FLIP;
    end

    // Resolve the output mode: companding wins over linear 8-bit.
    always_comb begin
        if (comp_en)        mode = MODE_COMP;
        else if (byte_mode) mode = MODE_LIN8;
        else                mode = MODE_PASS;
    end

    // Pick the byte and place it MSB-first, or pass the sample through whole.
    always_comb begin
        byte_val = (mode == MODE_COMP) ? code : in_sample[SAMPLE_W-1 -: CODE_W];
        if (mode == MODE_PASS)
            next_word = in_sample;
        else
            next_word = {byte_val, {(SAMPLE_W-CODE_W){1'b0}}};
    end

    // Output register: updates on valid samples and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= next_word;
        end
    end

    assign out_byte = out_word[SAMPLE_W-1 -: CODE_W];

    // R1: strobe latency of exactly one cycle.
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: without a sample the word holds.
    assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));
    // R8: the 8-bit modes leave the low byte zero.
    assert_byte_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (comp_en || byte_mode) |=> out_word[SAMPLE_W-CODE_W-1:0] == '0);
    // R9: pass-through keeps the whole sample.
    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !comp_en && !byte_mode |=> out_word == $past(in_sample));
    // R7: after inversion, the sign bit is set for non-negative samples.
    assert_sign_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && comp_en |=> out_byte[CODE_W-1] == !$past(in_sample[SAMPLE_W-1]));
endmodule

// File: tb/test_g711_compressor.sv
module test_g711_compressor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        comp_en = 1'b0;
    logic        law_sel = 1'b0;
    logic        byte_mode = 1'b0;
    logic        out_valid;
    logic [15:0] out_word;
    logic [7:0]  out_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    g711_compressor i_g711_compressor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .comp_en(comp_en), .law_sel(law_sel), .byte_mode(byte_mode),
        .out_valid(out_valid), .out_word(out_word), .out_byte(out_byte));

    // Segment-table µ-law reference (R3, R4, R7).
    function automatic logic [7:0] mu_ref(input logic [15:0] x);
        int v, m, seg, mant, code;
        v = int'($signed(x)) >>> 2;
        m = (v < 0) ? -v : v;
        if (m > 8191) m = 8191;
        if (m > 8158) m = 8158;
        m = m + 33;
        seg = 7;
        for (int s = 7; s >= 0; s--) if (m < (64 << s)) seg = s;
        mant = (m >> (seg + 1)) & 15;
        code = (seg << 4) | mant;
        return (v < 0) ? 8'(code ^ 8'h7F) : 8'(code ^ 8'hFF);
    endfunction

    // Segment-table A-law reference (R5, R6, R7).
    function automatic logic [7:0] a_ref(input logic [15:0] x);
        int v, m, seg, mant, code;
        v = int'($signed(x)) >>> 3;
        m = (v < 0) ? -v : v;
        if (m > 4095) m = 4095;
        seg = 7;
        for (int s = 7; s >= 0; s--) if (m < (32 << s)) seg = s;
        mant = (seg < 2) ? ((m >> 1) & 15) : ((m >> seg) & 15);
        code = (seg << 4) | mant;
        return (v < 0) ? 8'(code ^ 8'h55) : 8'(code ^ 8'hD5);
    endfunction

    // Expected output word for a sample and control setting (R2, R8, R9).
    function automatic logic [15:0] word_ref(input logic [15:0] x, input logic en,
                                             input logic law, input logic bm);
        if (en) return {(law ? a_ref(x) : mu_ref(x)), 8'h00};
        if (bm) return {x[15:8], 8'h00};
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one sample at a falling edge and check it one falling edge later.
    task automatic send(input logic [15:0] x, input logic en, input logic law,
                        input logic bm, input string req);
        logic [15:0] e;
        e = word_ref(x, en, law, bm);
        @(negedge clk);
        in_sample = x; comp_en = en; law_sel = law; byte_mode = bm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check(req, 32'(out_word), 32'(e));
        check({req, " byte"}, 32'(out_byte), 32'(e[15:8]));
    endtask

    task automatic fixed(input logic [15:0] x, input logic law, input logic [7:0] e,
                         input string req);
        @(negedge clk);
        in_sample = x; comp_en = 1'b1; law_sel = law; byte_mode = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, 32'(out_byte), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset word", 32'(out_word), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Known codes (R4, R5, R7).
        fixed(16'h0000, 1'b0, 8'hFF, "R7 mu zero");
        fixed(16'h0000, 1'b1, 8'hD5, "R7 a zero");
        fixed(16'h7FFF, 1'b0, 8'h80, "R4 mu full positive");
        fixed(16'h8000, 1'b0, 8'h00, "R4 mu full negative");
        fixed(16'h7FFF, 1'b1, 8'hAA, "R5 a full positive");
        fixed(16'h8000, 1'b1, 8'h2A, "R5 a full negative");

        // Unit steps and segment edges, both signs.
        for (int s = -1; s <= 1; s++) begin
            send(16'(s * 4), 1'b1, 1'b0, 1'b0, "R3 mu unit");
            send(16'(s * 8), 1'b1, 1'b1, 1'b0, "R6 a unit");
        end
        for (int k = 6; k <= 13; k++) begin
            for (int d = 32; d <= 34; d++) begin
                send(16'(((1 << k) - d) * 4), 1'b1, 1'b0, 1'b0, "R3 mu edge");
                send(16'(-((1 << k) - d) * 4), 1'b1, 1'b0, 1'b0, "R3 mu edge neg");
            end
        end
        for (int m = 8150; m <= 8191; m += 3)
            send(16'(m * 4), 1'b1, 1'b0, 1'b0, "R4 mu clip band");
        for (int k = 5; k <= 12; k++) begin
            for (int d = -1; d <= 0; d++) begin
                send(16'(((1 << k) + d) * 8), 1'b1, 1'b1, 1'b0, "R5 a edge");
                send(16'(-((1 << k) + d) * 8), 1'b1, 1'b1, 1'b0, "R5 a edge neg");
            end
        end
        for (int m = 0; m < 32; m += 5)
            send(16'(m * 8), 1'b1, 1'b1, 1'b0, "R6 a small");

        // Precedence and linear modes (R2, R8, R9).
        send(16'h1234, 1'b1, 1'b0, 1'b1, "R2 comp over byte");
        send(16'hA5C3, 1'b0, 1'b1, 1'b1, "R9 linear byte");
        send(16'hA5C3, 1'b0, 1'b0, 1'b0, "R9 pass-through");
        send(16'h00FF, 1'b0, 1'b1, 1'b0, "R8 low byte zero");

        // Hold without valid (R10).
        held = out_word;
        @(negedge clk);
        in_sample = 16'h5A5A; comp_en = 1'b0; byte_mode = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R10 hold word", 32'(out_word), 32'(held));
        check("R10 valid low", 32'(out_valid), 32'd0);

        // Random phase, weighted towards the range extremes.
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] x;
            logic [2:0]  ctl;
            int          pick;
            pick = int'($urandom % 4);
            if (pick == 0)      x = 16'h7FFF - 16'($urandom % 400);
            else if (pick == 1) x = 16'h8000 + 16'($urandom % 400);
            else                x = 16'($urandom);
            ctl = 3'($urandom);
            send(x, ctl[0] | ctl[2], ctl[1], ctl[2], "R2 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule